// File: doc/BRIEF.md
# Fixed-Point Add/Subtract Decode-Execute Unit

This block is the decode and execute slice for one family of integer instructions of a 64-bit RISC core: add and subtract-from, with their carrying, extended, minus-one and zero variants, the immediate carrying forms and an extended add that carries through the overflow bit. It is purely combinational. A 32-bit instruction word, the two source register values and the current carry, overflow and summary-overflow bits go in. The destination index, result, write enables and new status bits come out in the same cycle.

One shared adder serves every variant. The decoder picks the inputs to that adder: whether the first operand is inverted, what the second operand is (register, sign-extended immediate, all ones or zero) and what the carry in is (0, 1, the carry bit or the overflow bit). It also picks where the carry out and the overflow go. The overflow-enable and record bits of the instruction word enable the overflow and condition-field updates for every register form. Any word that matches no listed encoding raises the illegal flag and suppresses every write.

The source-field indices are passed out so that a register file outside the block can supply the operand values.

Top module: `aluadd_core`

## Requirements
- R1: Bit 31 is the most significant bit of the word. The primary opcode is insn[31:26], the destination index is insn[25:21] and the source indices are insn[20:16] (A) and insn[15:11] (B). A legal word drives rd_idx from its destination field and sets rd_we.
- R2: Register forms use primary opcode 31. The overflow-enable bit is insn[10], the 9-bit extended opcode is insn[9:1] and the record bit is insn[0]. The extended opcode for add is 100001010, giving A+B. The extended opcode for subf is 000101000, giving B-A. Neither one writes the carry bit.
- R3: The extended opcode for addc is 000001010, giving A+B. The extended opcode for subfc is 000001000, giving ~A+B+1. Both write the carry out of bit 63 to CA and the carry out of bit 31 to CA32.
- R4: The carry bit is the carry in, and CA and CA32 are written, for these extended opcodes: adde 010001010 (A+B), subfe 010001000 (~A+B), addme 011101010 (A plus all ones), subfme 011101000 (~A plus all ones), addze 011001010 (A+0) and subfze 011001000 (~A+0). For the minus-one and zero forms the B value is ignored.
- R5: Primary opcode 12 computes A+sext(insn[15:0]), opcode 13 does the same and also updates CR0, and opcode 8 computes ~A+sext(insn[15:0])+1. All three write CA and CA32 and never write OV or SO.
- R6: With the overflow-enable bit set on a register form, ov_we and so_we are asserted. OV and OV32 then carry the signed overflow at bit 63 and at bit 31, and so_o is so_i OR OV. SO is never cleared. With the bit clear, OV and SO are not written.
- R7: With the record bit set on a register form, and for opcode 13, cr0_o = {LT,GT,EQ,SO} is written, bits 3 down to 0. LT, GT and EQ come from the signed 64-bit result compared against zero, and SO is the value after this instruction's overflow update.
- R8: The extended add (opcode 31 with insn[10:1] = 0010101010, insn[0] ignored) computes A+B+OV. It writes the carry out of bit 63 to OV and the carry out of bit 31 to OV32. It writes neither CA nor CR0 and leaves SO unchanged.
- R9: Every other word, including the extended add with a nonzero insn[10:9], sets illegal and clears rd_we, ca_we, ov_we, so_we and cr0_we.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| insn | input | 32 | Instruction word |
| ra_val | input | 64 | Value of source register A |
| rb_val | input | 64 | Value of source register B |
| ca_i | input | 1 | Current carry bit |
| ov_i | input | 1 | Current overflow bit |
| so_i | input | 1 | Current summary-overflow bit |
| src_a_idx | output | 5 | Index of source A |
| src_b_idx | output | 5 | Index of source B |
| rd_idx | output | 5 | Destination index |
| rd_we | output | 1 | Destination write enable |
| rd_data | output | 64 | Result |
| ca_we | output | 1 | CA/CA32 write enable |
| ca_o | output | 1 | New CA |
| ca32_o | output | 1 | New CA32 |
| ov_we | output | 1 | OV/OV32 write enable |
| ov_o | output | 1 | New OV |
| ov32_o | output | 1 | New OV32 |
| so_we | output | 1 | SO write enable |
| so_o | output | 1 | New SO |
| cr0_we | output | 1 | CR0 write enable |
| cr0_o | output | 4 | New CR0 {LT,GT,EQ,SO} |
| illegal | output | 1 | Unmatched encoding |

## Verification
The block has no registers, so every output is due in the same cycle as the inputs that produce it, with no latency on any path. The bench drives each new word and operand set 1 ns after a rising edge and samples 2 ns later, well before the next edge. Each sample therefore sees settled values, and no result depends on the edge. The expected values come from a 65-bit sum and a separate 33-bit sum of the low halves, both formed from the rules above. Fields that an instruction does not write are compared only when the expected enable is set.

// File: rtl/aluadd_pkg.sv
package aluadd_pkg;

   typedef enum logic [1:0] {
      BSEL_REG  = 2'd0,
      BSEL_IMM  = 2'd1,
      BSEL_ONES = 2'd2,
      BSEL_ZERO = 2'd3
   } bsel_e;

   typedef enum logic [1:0] {
      CIN_ZERO = 2'd0,
      CIN_ONE  = 2'd1,
      CIN_CA   = 2'd2,
      CIN_OV   = 2'd3
   } cin_e;

   typedef struct packed {
      logic  legal;
      logic  inv_a;
      bsel_e bsel;
      cin_e  cin;
      logic  ca_wr;
      logic  oe_wr;
      logic  ov_carry;
      logic  cr_wr;
   } ctrl_t;

   localparam logic [5:0] PO_REG     = 6'd31;
   localparam logic [5:0] PO_ADDIC   = 6'd12;
   localparam logic [5:0] PO_ADDIC_R = 6'd13;
   localparam logic [5:0] PO_SUBFIC  = 6'd8;

   localparam logic [8:0] XO_ADD    = 9'b100001010;
   localparam logic [8:0] XO_ADDC   = 9'b000001010;
   localparam logic [8:0] XO_ADDE   = 9'b010001010;
   localparam logic [8:0] XO_ADDME  = 9'b011101010;
   localparam logic [8:0] XO_ADDZE  = 9'b011001010;
   localparam logic [8:0] XO_SUBF   = 9'b000101000;
   localparam logic [8:0] XO_SUBFC  = 9'b000001000;
   localparam logic [8:0] XO_SUBFE  = 9'b010001000;
   localparam logic [8:0] XO_SUBFME = 9'b011101000;
   localparam logic [8:0] XO_SUBFZE = 9'b011001000;
   localparam logic [8:0] XO_ADDEX  = 9'b010101010;

endpackage

// File: rtl/aluadd_decode.sv
module aluadd_decode
   import aluadd_pkg::*;
#(
   parameter int IW = 32
) (
   input  logic [IW-1:0] insn,
   output ctrl_t         ctl
);
   initial begin
      assert (IW == 32) else $error("aluadd_decode: IW must be 32");
   end

   logic [5:0] po;
   logic [8:0] xo;
   logic       oe_bit;
   logic       rc_bit;

   assign po     = insn[31:26];
   assign xo     = insn[9:1];
   assign oe_bit = insn[10];
   assign rc_bit = insn[0];

   function automatic ctrl_t mk(input logic inv, input bsel_e b, input cin_e c,
                                input logic caw, input logic oew,
                                input logic ovc, input logic crw);
      ctrl_t t;
      t.legal    = 1'b1;
      t.inv_a    = inv;
      t.bsel     = b;
      t.cin      = c;
      t.ca_wr    = caw;
      t.oe_wr    = oew;
      t.ov_carry = ovc;
      t.cr_wr    = crw;
      return t;
   endfunction

   always_comb begin
      ctl = '0;
      ctl.bsel = BSEL_REG;
      ctl.cin  = CIN_ZERO;
      case (po)
         PO_ADDIC:   ctl = mk(1'b0, BSEL_IMM, CIN_ZERO, 1'b1, 1'b0, 1'b0, 1'b0);
         PO_ADDIC_R: ctl = mk(1'b0, BSEL_IMM, CIN_ZERO, 1'b1, 1'b0, 1'b0, 1'b1);
         PO_SUBFIC:  ctl = mk(1'b1, BSEL_IMM, CIN_ONE,  1'b1, 1'b0, 1'b0, 1'b0);
         PO_REG: begin
            case (xo)
               XO_ADD:    ctl = mk(1'b0, BSEL_REG,  CIN_ZERO, 1'b0, oe_bit, 1'b0, rc_bit);
               XO_ADDC:   ctl = mk(1'b0, BSEL_REG,  CIN_ZERO, 1'b1, oe_bit, 1'b0, rc_bit);
               XO_ADDE:   ctl = mk(1'b0, BSEL_REG,  CIN_CA,   1'b1, oe_bit, 1'b0, rc_bit);
               XO_ADDME:  ctl = mk(1'b0, BSEL_ONES, CIN_CA,   1'b1, oe_bit, 1'b0, rc_bit);
               XO_ADDZE:  ctl = mk(1'b0, BSEL_ZERO, CIN_CA,   1'b1, oe_bit, 1'b0, rc_bit);
               XO_SUBF:   ctl = mk(1'b1, BSEL_REG,  CIN_ONE,  1'b0, oe_bit, 1'b0, rc_bit);
               XO_SUBFC:  ctl = mk(1'b1, BSEL_REG,  CIN_ONE,  1'b1, oe_bit, 1'b0, rc_bit);
               XO_SUBFE:  ctl = mk(1'b1, BSEL_REG,  CIN_CA,   1'b1, oe_bit, 1'b0, rc_bit);
               XO_SUBFME: ctl = mk(1'b1, BSEL_ONES, CIN_CA,   1'b1, oe_bit, 1'b0, rc_bit);
               XO_SUBFZE: ctl = mk(1'b1, BSEL_ZERO, CIN_CA,   1'b1, oe_bit, 1'b0, rc_bit);
               XO_ADDEX: begin
                  if (!oe_bit)
                     ctl = mk(1'b0, BSEL_REG, CIN_OV, 1'b0, 1'b0, 1'b1, 1'b0);
               end
               default: ;
            endcase
         end
         default: ;
      endcase
   end

   // immediate forms always carry and never take the overflow path
   always_comb begin
      if (po == PO_ADDIC || po == PO_ADDIC_R || po == PO_SUBFIC)
         p_imm_no_oe_r5: assert (ctl.ca_wr && !ctl.oe_wr && !ctl.ov_carry)
            else $error("p_imm_no_oe_r5");
      if (ctl.ov_carry)
         p_addex_isolated_r8: assert (!ctl.ca_wr && !ctl.cr_wr && !ctl.oe_wr)
            else $error("p_addex_isolated_r8");
   end

endmodule

// File: rtl/aluadd_operands.sv
module aluadd_operands
   import aluadd_pkg::*;
#(
   parameter int XLEN  = 64,
   parameter int IMM_W = 16
) (
   input  ctrl_t            ctl,
   input  logic [XLEN-1:0]  ra_val,
   input  logic [XLEN-1:0]  rb_val,
   input  logic [IMM_W-1:0] imm,
   input  logic             ca_i,
   input  logic             ov_i,
   output logic [XLEN-1:0]  op_x,
   output logic [XLEN-1:0]  op_y,
   output logic             cin
);
   localparam int EXT_W = XLEN - IMM_W;

   initial begin
      assert (IMM_W < XLEN) else $error("aluadd_operands: IMM_W too wide");
   end

   logic [XLEN-1:0] imm_sx;
   assign imm_sx = {{EXT_W{imm[IMM_W-1]}}, imm};
   assign op_x   = ctl.inv_a ? ~ra_val : ra_val;

   always_comb begin
      unique case (ctl.bsel)
         BSEL_REG:  op_y = rb_val;
         BSEL_IMM:  op_y = imm_sx;
         BSEL_ONES: op_y = '1;
         default:   op_y = '0;
      endcase
      unique case (ctl.cin)
         CIN_ZERO: cin = 1'b0;
         CIN_ONE:  cin = 1'b1;
         CIN_CA:   cin = ca_i;
         default:  cin = ov_i;
      endcase
   end

endmodule

// File: rtl/aluadd_adder.sv
module aluadd_adder #(
   parameter int XLEN   = 64,
   parameter int HALF_W = 32,
   parameter bit SPLIT  = 1'b1
) (
   input  logic [XLEN-1:0] op_x,
   input  logic [XLEN-1:0] op_y,
   input  logic            cin,
   output logic [XLEN-1:0] sum,
   output logic            co,
   output logic            co_half,
   output logic            ovf,
   output logic            ovf_half
);
   localparam int HI_W = XLEN - HALF_W;

   initial begin
      assert (HALF_W > 0 && HALF_W < XLEN) else $error("aluadd_adder: bad HALF_W");
   end

   logic [HALF_W:0] lo;
   assign lo = {1'b0, op_x[HALF_W-1:0]} + {1'b0, op_y[HALF_W-1:0]} + {{HALF_W{1'b0}}, cin};
   assign co_half = lo[HALF_W];

   generate
      if (SPLIT) begin : g_split
         logic [HI_W:0] hi;
         assign hi  = {1'b0, op_x[XLEN-1:HALF_W]} + {1'b0, op_y[XLEN-1:HALF_W]}
                    + {{HI_W{1'b0}}, lo[HALF_W]};
         assign sum = {hi[HI_W-1:0], lo[HALF_W-1:0]};
         assign co  = hi[HI_W];
      end else begin : g_flat
         logic [XLEN:0] full;
         assign full = {1'b0, op_x} + {1'b0, op_y} + {{XLEN{1'b0}}, cin};
         assign sum  = full[XLEN-1:0];
         assign co   = full[XLEN];
      end
   endgenerate

   assign ovf      = (op_x[XLEN-1] == op_y[XLEN-1]) && (sum[XLEN-1] != op_x[XLEN-1]);
   assign ovf_half = (op_x[HALF_W-1] == op_y[HALF_W-1]) && (sum[HALF_W-1] != op_x[HALF_W-1]);

   // an overflow can only come from two like-signed operands
   always_comb begin
      if (ovf)
         p_ovf_sign_r6: assert (op_x[XLEN-1] == op_y[XLEN-1] && sum[XLEN-1] != op_y[XLEN-1])
            else $error("p_ovf_sign_r6");
   end

endmodule

// File: rtl/aluadd_core.sv
module aluadd_core
   import aluadd_pkg::*;
#(
   parameter int XLEN   = 64,
   parameter int HALF_W = 32,
   parameter int IMM_W  = 16,
   parameter bit SPLIT  = 1'b1
) (
   input  logic [31:0]      insn,
   input  logic [XLEN-1:0]  ra_val,
   input  logic [XLEN-1:0]  rb_val,
   input  logic             ca_i,
   input  logic             ov_i,
   input  logic             so_i,
   output logic [4:0]       src_a_idx,
   output logic [4:0]       src_b_idx,
   output logic [4:0]       rd_idx,
   output logic             rd_we,
   output logic [XLEN-1:0]  rd_data,
   output logic             ca_we,
   output logic             ca_o,
   output logic             ca32_o,
   output logic             ov_we,
   output logic             ov_o,
   output logic             ov32_o,
   output logic             so_we,
   output logic             so_o,
   output logic             cr0_we,
   output logic [3:0]       cr0_o,
   output logic             illegal
);
   initial begin
      assert (XLEN > HALF_W) else $error("aluadd_core: XLEN must exceed HALF_W");
      assert (IMM_W == 16) else $error("aluadd_core: IMM_W must be 16");
   end

   ctrl_t           ctl;
   logic [XLEN-1:0] op_x, op_y, sum;
   logic            cin, co, co_half, ovf, ovf_half;

   aluadd_decode #(.IW(32)) u_dec (
      .insn (insn),
      .ctl  (ctl)
   );

   aluadd_operands #(.XLEN(XLEN), .IMM_W(IMM_W)) u_opnd (
      .ctl    (ctl),
      .ra_val (ra_val),
      .rb_val (rb_val),
      .imm    (insn[IMM_W-1:0]),
      .ca_i   (ca_i),
      .ov_i   (ov_i),
      .op_x   (op_x),
      .op_y   (op_y),
      .cin    (cin)
   );

   aluadd_adder #(.XLEN(XLEN), .HALF_W(HALF_W), .SPLIT(SPLIT)) u_add (
      .op_x     (op_x),
      .op_y     (op_y),
      .cin      (cin),
      .sum      (sum),
      .co       (co),
      .co_half  (co_half),
      .ovf      (ovf),
      .ovf_half (ovf_half)
   );

   assign src_a_idx = insn[20:16];
   assign src_b_idx = insn[15:11];
   assign rd_idx    = insn[25:21];
   assign illegal   = !ctl.legal;
   assign rd_we     = ctl.legal;
   assign rd_data   = sum;

   assign ca_we  = ctl.legal && ctl.ca_wr;
   assign ca_o   = co;
   assign ca32_o = co_half;

   assign ov_we  = ctl.legal && (ctl.oe_wr || ctl.ov_carry);
   assign ov_o   = ctl.ov_carry ? co      : ovf;
   assign ov32_o = ctl.ov_carry ? co_half : ovf_half;

   assign so_we  = ctl.legal && ctl.oe_wr;
   assign so_o   = so_i || (ctl.oe_wr && ovf);

   logic res_zero;
   assign res_zero = (sum == '0);
   assign cr0_we   = ctl.legal && ctl.cr_wr;
   assign cr0_o    = {sum[XLEN-1], !sum[XLEN-1] && !res_zero, res_zero, so_o};

   always_comb begin
      if (illegal)
         p_illegal_quiet_r9: assert (!rd_we && !ca_we && !ov_we && !so_we && !cr0_we)
            else $error("p_illegal_quiet_r9");
      if (so_i)
         p_so_sticky_r6: assert (so_o) else $error("p_so_sticky_r6");
      if (cr0_we)
         p_cr0_onehot_r7: assert ($onehot(cr0_o[3:1])) else $error("p_cr0_onehot_r7");
   end

endmodule

// File: tb/aluadd_core_tb.sv
module aluadd_core_tb;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic [31:0] insn;
   logic [63:0] ra_val, rb_val, rd_data;
   logic ca_i, ov_i, so_i;
   logic [4:0] src_a_idx, src_b_idx, rd_idx;
   logic rd_we, ca_we, ca_o, ca32_o, ov_we, ov_o, ov32_o, so_we, so_o, cr0_we, illegal;
   logic [3:0] cr0_o;

   aluadd_core u_dut (
      .insn(insn), .ra_val(ra_val), .rb_val(rb_val), .ca_i(ca_i), .ov_i(ov_i), .so_i(so_i),
      .src_a_idx(src_a_idx), .src_b_idx(src_b_idx), .rd_idx(rd_idx), .rd_we(rd_we),
      .rd_data(rd_data), .ca_we(ca_we), .ca_o(ca_o), .ca32_o(ca32_o), .ov_we(ov_we),
      .ov_o(ov_o), .ov32_o(ov32_o), .so_we(so_we), .so_o(so_o), .cr0_we(cr0_we),
      .cr0_o(cr0_o), .illegal(illegal)
   );

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;
   int cycles  = 0;

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > 190000 && !done) begin
         done = 1'b1;
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual cycles=%0d expected below 190000", cycles);
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   task automatic chk(input string tag, input logic [95:0] act, input logic [95:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s insn=%h a=%h b=%h: actual %h expected %h",
                  tag, insn, ra_val, rb_val, act, exp);
      end
   endtask

   task automatic apply(input logic [31:0] w, input logic [63:0] a, input logic [63:0] b,
                        input logic c, input logic o, input logic s);
      @(posedge clk);
      #1;
      insn = w; ra_val = a; rb_val = b; ca_i = c; ov_i = o; so_i = s;
      #2;
   endtask

   function automatic logic [63:0] opval(input int k);
      case (k)
         0: return 64'h0;
         1: return 64'h1;
         2: return '1;
         3: return 64'h7FFF_FFFF_FFFF_FFFF;
         4: return 64'h8000_0000_0000_0000;
         5: return 64'h0000_0000_FFFF_FFFF;
         6: return 64'h0000_0000_8000_0000;
         default: return 64'h1234_5678_9ABC_DEF0;
      endcase
   endfunction

   function automatic logic [15:0] immval(input int k);
      case (k)
         0: return 16'h0000;
         1: return 16'h0001;
         2: return 16'hFFFF;
         3: return 16'h7FFF;
         4: return 16'h8000;
         5: return 16'h1234;
         6: return 16'hFFFE;
         default: return 16'h00FF;
      endcase
   endfunction

   // ops 0..9: add addc adde addme addze subf subfc subfe subfme subfze
   function automatic logic [8:0] xo_of(input int k);
      case (k)
         0: return 9'b100001010;
         1: return 9'b000001010;
         2: return 9'b010001010;
         3: return 9'b011101010;
         4: return 9'b011001010;
         5: return 9'b000101000;
         6: return 9'b000001000;
         7: return 9'b010001000;
         8: return 9'b011101000;
         default: return 9'b011001000;
      endcase
   endfunction

   // one stimulus: kind 0..9 register ops, 10 addic, 11 addic-record, 12 subfic, 13 extended add
   task automatic run_one(input int kind, input bit oe, input bit rc,
                          input int ia, input int ib, input int st);
      logic [63:0] a, b, x, y;
      logic [64:0] s;
      logic [32:0] lo;
      logic [15:0] imm;
      logic [4:0] rt;
      logic [31:0] w;
      logic c, o, sv, cin, inv, ca_wr, ov_wr, so_wr, cr_wr, addex, vf, vf32, so_n;
      logic e_ov, e_ov32;
      string tag;
      a = opval(ia);
      b = opval((ib + 3) % 8);
      imm = immval(ib);
      rt = 5'((ia * 5 + ib * 3 + st) % 32);
      c = st[0]; o = st[1]; sv = (st == 1) || (st == 3);
      addex = (kind == 13);
      inv = (kind >= 5 && kind <= 9) || kind == 12;
      if (kind < 10) begin
         w = {6'd31, rt, 5'(ia), 5'(ib), oe, xo_of(kind), rc};
         y = (kind % 5 == 3) ? '1 : (kind % 5 == 4) ? 64'h0 : b;
         cin = (kind % 5 >= 2) ? c : inv;
         ca_wr = (kind % 5 != 0);
         ov_wr = oe; cr_wr = rc;
         tag = (kind % 5 == 0) ? "R2" : (kind % 5 == 1) ? "R3" : "R4";
      end else if (kind < 13) begin
         w = {(kind == 12) ? 6'd8 : (kind == 10) ? 6'd12 : 6'd13, rt, 5'(ia), imm};
         y = {{48{imm[15]}}, imm};
         cin = inv; ca_wr = 1'b1; ov_wr = 1'b0; cr_wr = (kind == 11);
         tag = "R5";
      end else begin
         w = {6'd31, rt, 5'(ia), 5'(ib), 10'b0010101010, rc};
         y = b; cin = o; ca_wr = 1'b0; ov_wr = 1'b0; cr_wr = 1'b0;
         tag = "R8";
      end
      x = inv ? ~a : a;
      s = {1'b0, x} + {1'b0, y} + {64'h0, cin};
      lo = {1'b0, x[31:0]} + {1'b0, y[31:0]} + {32'h0, cin};
      vf   = (x[63] == y[63]) && (s[63] != x[63]);
      vf32 = (x[31] == y[31]) && (s[31] != x[31]);
      so_wr = ov_wr;
      so_n = sv | (ov_wr & vf);
      e_ov   = addex ? s[64] : vf;
      e_ov32 = addex ? lo[32] : vf32;
      apply(w, a, b, c, o, sv);
      // R1: destination and source fields, write enable
      chk("R1", {81'h0, rd_idx, src_a_idx, src_b_idx, rd_we, illegal},
                {81'h0, rt, 5'(ia), (kind >= 10 && kind <= 12) ? imm[15:11] : 5'(ib), 1'b1, 1'b0});
      chk(tag, {29'h0, rd_data, ca_we, ca_we & ca_o, ca_we & ca32_o},
               {29'h0, s[63:0], ca_wr, ca_wr & s[64], ca_wr & lo[32]});
      chk(addex ? "R8" : "R6",
          {91'h0, ov_we, ov_we & ov_o, ov_we & ov32_o, so_we, so_o},
          {91'h0, ov_wr | addex, (ov_wr | addex) & e_ov, (ov_wr | addex) & e_ov32, so_wr, so_n});
      chk("R7", {91'h0, cr0_we, cr0_we ? cr0_o : 4'h0},
                {91'h0, cr_wr, cr_wr ? {s[63], !s[63] && s[63:0] != 0, s[63:0] == 0, so_n} : 4'h0});
   endtask

   function automatic bit legal31(input logic [9:0] v);
      for (int k = 0; k < 10; k++) if (v[8:0] == xo_of(k)) return 1'b1;
      return (v == 10'b0010101010);
   endfunction

   task automatic chk_bad(input logic [31:0] w);
      apply(w, 64'h5, 64'h9, 1'b1, 1'b1, 1'b0);
      chk("R9", {90'h0, illegal, rd_we, ca_we, ov_we, so_we, cr0_we}, {90'h0, 6'b100000});
   endtask

   initial begin
      insn = 32'h0; ra_val = '0; rb_val = '0; ca_i = 0; ov_i = 0; so_i = 0;
      repeat (3) @(posedge clk);
      #3;
      // reset-time idle word (opcode 0) must write nothing: R9
      chk("R9", {90'h0, illegal, rd_we, ca_we, ov_we, so_we, cr0_we}, {90'h0, 6'b100000});
      rst_n = 1'b1;
      for (int k = 0; k < 10; k++)
         for (int m = 0; m < 4; m++)
            for (int ia = 0; ia < 8; ia++)
               for (int ib = 0; ib < 8; ib++)
                  for (int st = 0; st < 4; st++)
                     run_one(k, m[1], m[0], ia, ib, st);
      for (int k = 10; k < 14; k++)
         for (int rc = 0; rc < 2; rc++)
            for (int ia = 0; ia < 8; ia++)
               for (int ib = 0; ib < 8; ib++)
                  for (int st = 0; st < 4; st++)
                     run_one(k, 1'b0, rc[0], ia, ib, st);
      for (int p = 0; p < 64; p++)
         if (p != 8 && p != 12 && p != 13 && p != 31)
            chk_bad({6'(p), 26'h2A5_A5A5});
      for (int v = 0; v < 1024; v++)
         if (!legal31(10'(v)))
            chk_bad({6'd31, 5'd7, 5'd3, 5'd4, 10'(v), v[0]});
      if (!done) begin
         done = 1'b1;
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

endmodule